// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming serial characters in memory buffers. A small descriptor RAM holds a circular table of receive descriptors. Each descriptor names one buffer and says whether software has handed that buffer over. The engine walks the table one descriptor at a time. For each buffer it keeps a write address and a down-counting byte budget.

A buffer closes when the budget runs out, when a byte arrives flagged as end of frame, or when a byte arrives flagged as bad. On close, the engine writes the stored byte count and the updated status back into the descriptor and pulses `done`. It then moves to the next descriptor. If the closed descriptor carries the wrap flag, the next descriptor is the one at the table base. Every descriptor is 8 bytes: status halfword at offset 0, length halfword at offset 2, buffer address high half at offset 4 and low half at offset 6.

The character input and the memory write port are valid/ready streams. While a buffer is open, the input is passed through to the memory port combinationally, so `in_ready` follows `mw_ready` and a stalled memory stalls the source. Outside an open buffer, `in_ready` is low, except when the current descriptor is not handed over: bytes are then accepted and thrown away. The descriptor RAM read port returns data one cycle after the address.

Top module: `rx_desc_ring`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `mw_valid`, `done` and `busy` are 0. After reset is released, the first descriptor is read at `rx_base` with its low three bits taken as zero.
- R2: When the closed descriptor has the wrap flag (status bit 13) set, the next descriptor read is at the aligned base. Otherwise it is 8 bytes further on. Only the wrap flag sets the ring size.
- R3: At each descriptor fetch the budget is loaded from `max_len`. A buffer with no early close receives exactly `max_len` bytes, and its length field then reads `max_len`.
- R4: A byte flagged `in_eof` is stored, then the buffer closes. The length field holds the number of bytes stored, and the last flag (status bit 11) is set.
- R5: A byte flagged `in_err` is stored, then the buffer closes with the error flag (status bit 1) set.
- R6: Byte k (counting from 0) of a buffer is written to memory at the buffer address plus k. The buffer address is the high halfword (offset 4) joined with the low halfword (offset 6).
- R7: A new `max_len` applied while a buffer is open does not change that buffer. It takes effect from the next descriptor fetch.
- R8: If the empty flag (status bit 15) of the current descriptor is clear, each arriving byte is accepted and dropped. The engine writes nothing to memory, pulses `busy` for one cycle, and reads the descriptor again.
- R9: On close, the length is written at offset 2, then the status at offset 0 with the empty flag cleared and the wrap flag kept. `done` pulses for one cycle per closed buffer.
- R10: While a buffer is open, `in_ready` equals `mw_ready`. Each accepted byte gives exactly one memory write, with no byte lost or repeated under any stall pattern.
- R11: The engine never writes the two address halfwords of a descriptor. Descriptor words sit at offsets 0, 2, 4 and 6 from an 8-byte-aligned start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_base | input | DA_W | Descriptor table base byte address (low 3 bits ignored) |
| max_len | input | LEN_W | Maximum bytes per buffer; nonzero, even for wide characters |
| in_valid | input | 1 | Character byte valid |
| in_ready | output | 1 | Character byte accepted |
| in_data | input | 8 | Character byte |
| in_eof | input | 1 | Byte ends a frame |
| in_err | input | 1 | Byte was received with an error |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | MA_W | Memory byte address |
| mw_data | output | 8 | Memory write data |
| dr_addr | output | DA_W | Descriptor RAM read byte address (even) |
| dr_rdata | input | 16 | Descriptor RAM read data, one cycle after address |
| dw_en | output | 1 | Descriptor RAM write enable |
| dw_addr | output | DA_W | Descriptor RAM write byte address (even) |
| dw_data | output | 16 | Descriptor RAM write data |
| busy | output | 1 | One-cycle pulse per byte dropped for lack of a buffer |
| done | output | 1 | One-cycle pulse per closed buffer |

## Verification
Two close causes can land on the same byte: budget exhaustion and end of frame (or error). The sweep over buffer length against frame length provokes this whenever the frame length is a multiple of the budget. A correct engine must then close exactly once, store the full budget and set the last or error flag, and the ring must advance by one descriptor only. A second collision is a `max_len` change that arrives just before a descriptor fetch. It is judged by the length written to the buffer opened after the change.

// File: rtl/rx_desc_ring_pkg.sv
package rx_desc_ring_pkg;
  typedef enum logic [3:0] {
    ST_INIT, ST_RD_STAT, ST_RD_HI, ST_RD_LO, ST_DECIDE,
    ST_FILL, ST_HOLD, ST_WB_LEN, ST_WB_STAT
  } rx_state_t;

  localparam int BIT_EMPTY = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_LAST  = 11;
  localparam int BIT_ERR   = 1;

  localparam int OFS_STAT = 0;
  localparam int OFS_LEN  = 2;
  localparam int OFS_AHI  = 4;
  localparam int OFS_ALO  = 6;
  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int DA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            advance,
  input  logic            wrap,
  input  logic [DA_W-1:0] base,
  output logic [DA_W-1:0] ptr
);
  import rx_desc_ring_pkg::*;

  localparam logic [DA_W-1:0] ALIGN_MASK = ~DA_W'(DESC_BYTES - 1);
  localparam logic [DA_W-1:0] STEP       = DA_W'(DESC_BYTES);

  logic [DA_W-1:0] base_al;
  assign base_al = base & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ptr <= '0;
    else if (init || (advance && wrap)) ptr <= base_al;
    else if (advance)                   ptr <= ptr + STEP;
  end

  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap) |=> (ptr == $past(base_al)));
endmodule

// File: rtl/rx_budget.sv
module rx_budget #(
  parameter int MA_W  = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [MA_W-1:0]  start_addr,
  input  logic [LEN_W-1:0] limit,
  output logic [MA_W-1:0]  dptr,
  output logic [LEN_W-1:0] used,
  output logic             last_byte
);
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr <= '0;
      left <= '0;
      used <= '0;
    end else if (load) begin
      dptr <= start_addr;
      left <= limit;
      used <= '0;
    end else if (step) begin
      dptr <= dptr + MA_W'(1);
      left <= left - LEN_W'(1);
      used <= used + LEN_W'(1);
    end
  end

  assign last_byte = (left == LEN_W'(1));

  // R3
  budget_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left != '0));

  // R6
  dptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (dptr == $past(dptr) + MA_W'(1)));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int DA_W  = 8,
  parameter int MA_W  = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DA_W-1:0]  rx_base,
  input  logic [LEN_W-1:0] max_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_eof,
  input  logic             in_err,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [MA_W-1:0]  mw_addr,
  output logic [7:0]       mw_data,
  output logic [DA_W-1:0]  dr_addr,
  input  logic [15:0]      dr_rdata,
  output logic             dw_en,
  output logic [DA_W-1:0]  dw_addr,
  output logic [15:0]      dw_data,
  output logic             busy,
  output logic             done
);
  import rx_desc_ring_pkg::*;

  rx_state_t        st;
  logic [15:0]      stat_q, ahi_q, stat_wb;
  logic [LEN_W-1:0] mrbl_sh, used;
  logic             end_eof, end_err;
  logic [DA_W-1:0]  ptr;
  logic [MA_W-1:0]  dptr;
  logic             last_byte, xfer, closing;

  rx_ring_ptr #(.DA_W(DA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .init(st == ST_INIT), .advance(st == ST_WB_STAT),
    .wrap(stat_q[BIT_WRAP]), .base(rx_base), .ptr(ptr)
  );

  rx_budget #(.MA_W(MA_W), .LEN_W(LEN_W)) u_bud (
    .clk(clk), .rst_n(rst_n),
    .load(st == ST_DECIDE), .step(xfer),
    .start_addr(MA_W'({ahi_q, dr_rdata})), .limit(max_len),
    .dptr(dptr), .used(used), .last_byte(last_byte)
  );

  // stream pass-through while a buffer is open
  always_comb begin
    mw_valid = (st == ST_FILL) && in_valid;
    in_ready = (st == ST_FILL) ? mw_ready : (st == ST_HOLD);
    mw_addr  = dptr;
    mw_data  = in_data;
    xfer     = mw_valid && mw_ready;
    closing  = xfer && (in_eof || in_err || last_byte);
  end

  always_comb begin
    case (st)
      ST_RD_HI: dr_addr = ptr + DA_W'(OFS_AHI);
      ST_RD_LO: dr_addr = ptr + DA_W'(OFS_ALO);
      default:  dr_addr = ptr + DA_W'(OFS_STAT);
    endcase
  end

  always_comb begin
    stat_wb            = stat_q;
    stat_wb[BIT_EMPTY] = 1'b0;
    stat_wb[BIT_LAST]  = stat_q[BIT_LAST] | end_eof;
    stat_wb[BIT_ERR]   = stat_q[BIT_ERR] | end_err;
    dw_en   = (st == ST_WB_LEN) || (st == ST_WB_STAT);
    dw_addr = (st == ST_WB_LEN) ? ptr + DA_W'(OFS_LEN) : ptr + DA_W'(OFS_STAT);
    dw_data = (st == ST_WB_LEN) ? 16'(used) : stat_wb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_INIT;
      stat_q  <= '0;
      ahi_q   <= '0;
      mrbl_sh <= '0;
      end_eof <= 1'b0;
      end_err <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      busy <= (st == ST_HOLD) && in_valid;
      done <= (st == ST_WB_STAT);
      case (st)
        ST_INIT:    st <= ST_RD_STAT;
        ST_RD_STAT: st <= ST_RD_HI;
        ST_RD_HI: begin
          stat_q <= dr_rdata;
          st     <= ST_RD_LO;
        end
        ST_RD_LO: begin
          ahi_q <= dr_rdata;
          st    <= ST_DECIDE;
        end
        ST_DECIDE: begin
          mrbl_sh <= max_len;
          end_eof <= 1'b0;
          end_err <= 1'b0;
          st      <= stat_q[BIT_EMPTY] ? ST_FILL : ST_HOLD;
        end
        ST_FILL: if (closing) begin
          end_eof <= in_eof;
          end_err <= in_err;
          st      <= ST_WB_LEN;
        end
        ST_HOLD:    if (in_valid) st <= ST_RD_STAT;
        ST_WB_LEN:  st <= ST_WB_STAT;
        ST_WB_STAT: st <= ST_RD_STAT;
        default:    st <= ST_INIT;
      endcase
    end
  end

  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB_LEN) |-> (used != '0 && used <= mrbl_sh));

  // R8
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> !mw_valid);

  // R9
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dw_en) && !$past(dw_data[BIT_EMPTY])));

  // R10
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (in_ready == mw_ready));
endmodule

// File: tb/rx_desc_ring_test.sv
`timescale 1ns/1ps
module rx_desc_ring_test;
  localparam int DA_W = 8, MA_W = 32, LEN_W = 16, ND = 3;

  logic clk = 0, rst_n = 0;
  logic [DA_W-1:0] rx_base = '0;
  logic [LEN_W-1:0] max_len = 16'd1;
  logic in_valid = 0, in_eof = 0, in_err = 0, mw_ready = 1;
  logic [7:0] in_data = '0;
  logic in_ready, mw_valid, dw_en, busy, done;
  logic [MA_W-1:0] mw_addr;
  logic [7:0] mw_data;
  logic [DA_W-1:0] dr_addr, dw_addr;
  logic [15:0] dr_rdata, dw_data;

  logic tb_we = 0;
  logic [6:0] tb_wa = '0;
  logic [15:0] tb_wd = '0;
  logic [15:0] dram [0:127];

  int n_cmp = 0, n_bad = 0, n_got = 0, n_done = 0, n_busy = 0, kk = 0;
  bit stall_on = 0;
  logic [MA_W-1:0] got_addr [0:63];
  logic [7:0] got_data [0:63];

  always #4 clk = ~clk;

  rx_desc_ring #(.DA_W(DA_W), .MA_W(MA_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_base(rx_base), .max_len(max_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_eof(in_eof), .in_err(in_err),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .dr_addr(dr_addr), .dr_rdata(dr_rdata),
    .dw_en(dw_en), .dw_addr(dw_addr), .dw_data(dw_data),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    dr_rdata <= dram[dr_addr[7:1]];
    if (dw_en) dram[dw_addr[7:1]] <= dw_data;
    if (tb_we) dram[tb_wa] <= tb_wd;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (mw_valid && mw_ready && n_got < 64) begin
        got_addr[n_got] = mw_addr;
        got_data[n_got] = mw_data;
        n_got++;
      end
      if (done) n_done++;
      if (busy) n_busy++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] s0(input int d);
    return 16'h8000 | ((d == ND-1) ? 16'h2000 : 16'h0000);
  endfunction

  function automatic logic [MA_W-1:0] bufaddr(input int d);
    return {16'(16'h0010 + d), 16'(16'h0200 * d + 16'h0040)};
  endfunction

  task automatic prog(input int hw, input logic [15:0] v);
    @(negedge clk);
    tb_we = 1; tb_wa = 7'(hw); tb_wd = v;
    @(negedge clk);
    tb_we = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic e, input logic r);
    @(negedge clk);
    in_valid = 1; in_data = b; in_eof = e; in_err = r;
    forever begin
      mw_ready = stall_on ? (kk % 3 != 2) : 1'b1;
      kk++;
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    in_valid = 0; in_eof = 0; in_err = 0; mw_ready = 1;
  endtask

  task automatic run_scn(input int mb0, input int mb1, input int chg, input int len,
                         input int term, input bit stall, input logic [7:0] basein,
                         input string len_tag);
    int base_hw, d, cnt, mb, ne, ed, eb, wbad;
    bit emp [ND];
    int elen [ND];
    logic [15:0] est [ND];
    logic [MA_W-1:0] ea [0:63];
    logic [7:0] edat [0:63];
    rst_n = 0; in_valid = 0; mw_ready = 1;
    max_len = LEN_W'(mb0); rx_base = basein; stall_on = stall;
    base_hw = int'(basein & 8'hF8) / 2;
    repeat (2) @(negedge clk);
    // R1: quiet outputs during reset
    chk(!in_ready && !mw_valid && !done && !busy, "R1", "reset outputs",
        {in_ready, mw_valid, done, busy}, 0);
    for (int k = 0; k < ND; k++) begin
      prog(base_hw + 4*k + 0, s0(k));
      prog(base_hw + 4*k + 1, 16'h0000);
      prog(base_hw + 4*k + 2, bufaddr(k)[31:16]);
      prog(base_hw + 4*k + 3, bufaddr(k)[15:0]);
      emp[k] = 1; elen[k] = 0; est[k] = s0(k);
    end
    n_got = 0; n_done = 0; n_busy = 0;
    @(negedge clk);
    rst_n = 1;
    d = 0; cnt = 0; mb = mb0; ne = 0; ed = 0; eb = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      bit e, r;
      b = 8'(i*37 + len*5 + mb0);
      e = (i == len-1) && (term == 0);
      r = (i == len-1) && (term == 1);
      if (i == chg) max_len = LEN_W'(mb1);
      send(b, e, r);
      if (!emp[d]) begin eb++; continue; end
      ea[ne] = bufaddr(d) + MA_W'(cnt); edat[ne] = b; ne++; cnt++;
      if (cnt == mb || e || r) begin
        elen[d] = cnt;
        est[d] = (s0(d) & 16'h7FFF) | (e ? 16'h0800 : 16'h0) | (r ? 16'h0002 : 16'h0);
        emp[d] = 0; ed++; d = (d + 1) % ND; cnt = 0;
        mb = (i + 1 >= chg) ? mb1 : mb0;
      end
    end
    repeat (12) @(negedge clk);
    // R10 R1: every accepted byte written once from the aligned base
    chk(n_got == ne, "R10 R1", "write count", n_got, ne);
    wbad = 0;
    for (int k = 0; k < ne && k < n_got; k++)
      if (got_addr[k] !== ea[k] || got_data[k] !== edat[k]) wbad++;
    // R6: byte placement
    chk(wbad == 0, "R6", "misplaced writes", wbad, 0);
    // R9: one done per closed buffer
    chk(n_done == ed, "R9", "done pulses", n_done, ed);
    // R8 R2: drops after wrapping to a used descriptor
    chk(n_busy == eb, "R8 R2", "busy pulses", n_busy, eb);
    for (int k = 0; k < ND; k++) begin
      chk(dram[base_hw + 4*k + 1] == 16'(elen[k]), len_tag, "length field",
          dram[base_hw + 4*k + 1], elen[k]);
      chk(dram[base_hw + 4*k] == est[k], term == 0 ? "R4 R9" : "R5 R9", "status field",
          dram[base_hw + 4*k], est[k]);
      // R11: address words untouched
      chk({dram[base_hw + 4*k + 2], dram[base_hw + 4*k + 3]} == bufaddr(k), "R11",
          "address words", {dram[base_hw + 4*k + 2], dram[base_hw + 4*k + 3]}, bufaddr(k));
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) dram[i] = '0;
    for (int mb = 1; mb <= 4; mb++)
      for (int len = 1; len <= 5; len++)
        for (int term = 0; term < 2; term++)
          run_scn(mb, mb, 99, len, term, ((mb + len + term) % 2) == 1,
                  (len % 2 == 1) ? 8'h13 : 8'h40, "R3");
    // R7: limit changes mid-buffer; first buffer keeps 4, next gets 2
    run_scn(4, 2, 2, 7, 0, 0, 8'h20, "R7");
    run_scn(4, 2, 2, 7, 0, 1, 8'h58, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule